// File: doc/BRIEF.md
# Process-Tagged Shared Translation Cache

This block is a small, fully associative translation cache that several accelerator agents share. Every entry is keyed by a process address space identifier together with the virtual page number of a 48-bit virtual address (4 KiB pages). A lookup that hits and passes its permission checks returns the physical address one cycle after it is accepted. A lookup that misses, or that breaks a permission rule, produces a fault record instead. The record holds the full virtual address, the process ID, the access direction, a cause code and the tag of the requesting device.

Only one fault may be outstanding. While it is pending, and during a replay, the request port is stalled. Software services the fault, typically by installing the translation through the refill port, and then acknowledges it. The acknowledge either asks for the held request to be translated again or drops it. Page-table walking is outside the block: a plain refill port installs entries. New keys are placed round-robin, and a refill for a key that is already present overwrites that entry in place. Invalidation clears every entry of one process ID, or every entry in the cache.

Agents always access at the lowest privilege level. An entry marked as reserved for higher privilege therefore faults on every lookup.

Top module: `xlat_cache`

## Requirements
- R1: A lookup is accepted on a clock edge where req_valid and req_ready are both high. If the key {req_pid, req_va[47:12]} matches a valid entry whose permissions allow the access, rsp_valid is high for exactly the next cycle, with rsp_pa = {entry physical page, req_va[11:0]} and rsp_dev = req_dev.
- R2: Matching needs both the process ID and the virtual page to be equal. The same page under another process ID misses, with cause 0.
- R3: Fault cause encodings are 0 = miss, 1 = privileged page, 2 = write to a page without write permission, 3 = read from a page without read permission. A privileged entry faults with cause 1 on any access, and cause 1 takes precedence over causes 2 and 3.
- R4: A faulting lookup raises fault_valid in the cycle after acceptance. fault_va (all 48 bits), fault_pid, fault_dev, fault_write and fault_cause describe that request and hold steady until fault_ack is sampled high.
- R5: Only one fault is outstanding. req_ready is low while fault_valid is high and for the one replay cycle after a retry acknowledge. rsp_valid and fault_valid are never high together.
- R6: If fault_ack is sampled with fault_retry = 1, the held request is looked up again in the next cycle, and its result (a response or a new fault) appears two cycles after the acknowledge edge. With fault_retry = 0 the request is dropped and req_ready is high in the next cycle. fault_ack has no effect when no fault is pending.
- R7: An invalidate with inv_all = 0 clears every entry whose process ID equals inv_pid and leaves other processes' entries intact.
- R8: An invalidate with inv_all = 1 clears every entry.
- R9: A refill for a key that is not present writes the round-robin slot, and the pointer then advances. A refill for a present key overwrites that entry and does not advance the pointer. So the ninth distinct new key after eight new keys evicts the first of those eight.
- R10: A lookup in the same cycle as a refill or invalidate sees the contents from before that cycle. When a refill and an invalidate share a cycle, the refill is applied last and its entry stays valid.
- R11: After reset no entry is valid, rsp_valid and fault_valid are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_va | input | VA_W | Virtual address |
| req_pid | input | PID_W | Process address space ID |
| req_dev | input | DEV_W | Requesting device tag |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_pa | output | PA_W | Physical address |
| rsp_dev | output | DEV_W | Device tag of the answered request |
| fault_valid | output | 1 | Fault record pending |
| fault_cause | output | 2 | Cause code (see R3) |
| fault_va | output | VA_W | Faulting virtual address |
| fault_pid | output | PID_W | Faulting process ID |
| fault_dev | output | DEV_W | Device tag of faulting request |
| fault_write | output | 1 | Faulting access was a write |
| fault_ack | input | 1 | Fault serviced acknowledge |
| fault_retry | input | 1 | With fault_ack: 1 = replay, 0 = drop |
| fill_valid | input | 1 | Refill entry strobe |
| fill_pid | input | PID_W | Refill process ID |
| fill_vpn | input | VA_W-12 | Refill virtual page number |
| fill_ppn | input | PA_W-12 | Refill physical page number |
| fill_read | input | 1 | Entry read permission |
| fill_write | input | 1 | Entry write permission |
| fill_priv | input | 1 | Entry reserved for higher privilege |
| inv_valid | input | 1 | Invalidate strobe |
| inv_all | input | 1 | 1 = clear all entries, 0 = one process |
| inv_pid | input | PID_W | Process ID to invalidate |

## Verification
Two pairs of functions can coincide. The first is a lookup landing in the same cycle as a global invalidate or a refill. The second is a refill landing in the same cycle as an invalidate. The bench raises req_valid, inv_valid and fill_valid on the same falling edge. It expects the lookup to hit (after an invalidate) or to miss (after a refill), because the lookup sees the old contents. A follow-up lookup then shows whether the change took effect. A refill issued together with a global invalidate must still hit afterwards. Replay also gets its own test: the fault is serviced by a refill before a retry acknowledge, and the replayed request then returns a response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    CAUSE_MISS    = 2'd0,
    CAUSE_PRIV    = 2'd1,
    CAUSE_NOWRITE = 2'd2,
    CAUSE_NOREAD  = 2'd3
  } xlat_cause_e;
endpackage

// File: rtl/xlat_rr_ptr.sv
module xlat_rr_ptr #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (advance) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end

  assign slot = ptr_q;
endmodule

// File: rtl/xlat_tag_store.sv
module xlat_tag_store #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 28
) (
  input  logic             clk,
  input  logic             rst,
  // lookup compare
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_rd,
  output logic             lk_wr,
  output logic             lk_sup,
  // refill
  input  logic             fill_valid,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_sup,
  input  logic [IDX_W-1:0] victim,
  output logic             fill_alloc,
  // invalidate
  input  logic             inv_valid,
  input  logic             inv_all,
  input  logic [PID_W-1:0] inv_pid
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] rd_q, wr_q, sup_q;
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  logic [ENTRIES-1:0] lk_vec, fl_vec;
  logic [IDX_W-1:0]   fl_idx, wr_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_vec[g] = vld_q[g] && (pid_q[g] == lk_pid)   && (vpn_q[g] == lk_vpn);
    assign fl_vec[g] = vld_q[g] && (pid_q[g] == fill_pid) && (vpn_q[g] == fill_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    lk_rd  = 1'b0;
    lk_wr  = 1'b0;
    lk_sup = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) begin
        lk_ppn = lk_ppn | ppn_q[i];
        lk_rd  = lk_rd  | rd_q[i];
        lk_wr  = lk_wr  | wr_q[i];
        lk_sup = lk_sup | sup_q[i];
      end
    end
  end
  assign lk_hit = |lk_vec;

  always_comb begin
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fl_vec[i]) fl_idx = IDX_W'(i);
    end
  end

  assign fill_alloc = fill_valid && !(|fl_vec);
  assign wr_idx     = (|fl_vec) ? fl_idx : victim;

  // valid bits: invalidate first, refill last
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (inv_valid) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (inv_all || (pid_q[i] == inv_pid)) vld_q[i] <= 1'b0;
        end
      end
      if (fill_valid) vld_q[wr_idx] <= 1'b1;
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      pid_q[wr_idx] <= fill_pid;
      vpn_q[wr_idx] <= fill_vpn;
      ppn_q[wr_idx] <= fill_ppn;
      rd_q[wr_idx]  <= fill_rd;
      wr_q[wr_idx]  <= fill_wr;
      sup_q[wr_idx] <= fill_sup;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int PID_W   = 8,
  parameter int DEV_W   = 4,
  parameter int ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_va,
  input  logic [PID_W-1:0]         req_pid,
  input  logic [DEV_W-1:0]         req_dev,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic [PA_W-1:0]          rsp_pa,
  output logic [DEV_W-1:0]         rsp_dev,
  output logic                     fault_valid,
  output logic [1:0]               fault_cause,
  output logic [VA_W-1:0]          fault_va,
  output logic [PID_W-1:0]         fault_pid,
  output logic [DEV_W-1:0]         fault_dev,
  output logic                     fault_write,
  input  logic                     fault_ack,
  input  logic                     fault_retry,
  input  logic                     fill_valid,
  input  logic [PID_W-1:0]         fill_pid,
  input  logic [VA_W-PAGE_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-PAGE_SHIFT-1:0] fill_ppn,
  input  logic                     fill_read,
  input  logic                     fill_write,
  input  logic                     fill_priv,
  input  logic                     inv_valid,
  input  logic                     inv_all,
  input  logic [PID_W-1:0]         inv_pid
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PPN_W = PA_W - PAGE_SHIFT;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             flt_q, rpl_q;
  logic             lk_go;
  logic [VA_W-1:0]  lk_va;
  logic [PID_W-1:0] lk_pid;
  logic [DEV_W-1:0] lk_dev;
  logic             lk_write;
  logic             lk_hit, lk_rd, lk_wr, lk_sup;
  logic [PPN_W-1:0] lk_ppn;
  logic [IDX_W-1:0] victim;
  logic             fill_alloc;
  logic             bad;
  xlat_cause_e      cause;

  assign req_ready = !flt_q && !rpl_q;
  assign lk_go     = (req_valid && req_ready) || rpl_q;

  // replay reuses the held fault record as its request
  always_comb begin
    if (rpl_q) begin
      lk_va    = fault_va;
      lk_pid   = fault_pid;
      lk_dev   = fault_dev;
      lk_write = fault_write;
    end else begin
      lk_va    = req_va;
      lk_pid   = req_pid;
      lk_dev   = req_dev;
      lk_write = req_write;
    end
  end

  xlat_tag_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .PID_W(PID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_pid    (lk_pid),
    .lk_vpn    (lk_va[VA_W-1:PAGE_SHIFT]),
    .lk_hit    (lk_hit),
    .lk_ppn    (lk_ppn),
    .lk_rd     (lk_rd),
    .lk_wr     (lk_wr),
    .lk_sup    (lk_sup),
    .fill_valid(fill_valid),
    .fill_pid  (fill_pid),
    .fill_vpn  (fill_vpn),
    .fill_ppn  (fill_ppn),
    .fill_rd   (fill_read),
    .fill_wr   (fill_write),
    .fill_sup  (fill_priv),
    .victim    (victim),
    .fill_alloc(fill_alloc),
    .inv_valid (inv_valid),
    .inv_all   (inv_all),
    .inv_pid   (inv_pid)
  );

  xlat_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk    (clk),
    .rst    (rst),
    .advance(fill_alloc),
    .slot   (victim)
  );

  // check priority: miss, privilege, then direction permission
  always_comb begin
    bad   = 1'b1;
    cause = CAUSE_MISS;
    if (!lk_hit) begin
      cause = CAUSE_MISS;
    end else if (lk_sup) begin
      cause = CAUSE_PRIV;
    end else if (lk_write && !lk_wr) begin
      cause = CAUSE_NOWRITE;
    end else if (!lk_write && !lk_rd) begin
      cause = CAUSE_NOREAD;
    end else begin
      bad = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q     <= 1'b0;
      rpl_q     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= lk_go && !bad;
      rpl_q     <= 1'b0;
      if (lk_go && bad) begin
        flt_q <= 1'b1;
      end else if (flt_q && fault_ack) begin
        flt_q <= 1'b0;
        rpl_q <= fault_retry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_go && !bad) begin
      rsp_pa  <= {lk_ppn, lk_va[PAGE_SHIFT-1:0]};
      rsp_dev <= lk_dev;
    end
    if (lk_go && bad) begin
      fault_cause <= cause;
      fault_va    <= lk_va;
      fault_pid   <= lk_pid;
      fault_dev   <= lk_dev;
      fault_write <= lk_write;
    end
  end

  assign fault_valid = flt_q;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W  = 48,
  parameter int DEV_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             fault_valid,
  input logic             fault_ack,
  input logic             fault_retry,
  input logic [VA_W-1:0]  fault_va,
  input logic [DEV_W-1:0] fault_dev
);
  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || fault_valid)); // R1

  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_va) && $stable(fault_dev))); // R4

  AST_STALL_WHILE_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> !req_ready); // R5

  AST_NO_DUAL_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fault_valid)); // R5

  AST_RETRY_REPLAYS: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_ack && fault_retry) |-> ##2 (rsp_valid || fault_valid)); // R6

  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_ack && !fault_retry) |=> (req_ready && !fault_valid)); // R6
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .DEV_W(DEV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .fault_valid(fault_valid),
  .fault_ack  (fault_ack),
  .fault_retry(fault_retry),
  .fault_va   (fault_va),
  .fault_dev  (fault_dev)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int VA_W = 48, PA_W = 40, PID_W = 8, DEV_W = 4, ENTRIES = 8;
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [VA_W-1:0] req_va = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic [DEV_W-1:0] req_dev = '0;
  logic req_ready, rsp_valid, fault_valid, fault_write;
  logic [PA_W-1:0] rsp_pa;
  logic [DEV_W-1:0] rsp_dev, fault_dev;
  logic [1:0] fault_cause;
  logic [VA_W-1:0] fault_va;
  logic [PID_W-1:0] fault_pid;
  logic fault_ack = 0, fault_retry = 0;
  logic fill_valid = 0, fill_read = 0, fill_write = 0, fill_priv = 0;
  logic [PID_W-1:0] fill_pid = '0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic inv_valid = 0, inv_all = 0;
  logic [PID_W-1:0] inv_pid = '0;

  xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W), .DEV_W(DEV_W), .ENTRIES(ENTRIES))
  u_xlat_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_pid(req_pid),
    .req_dev(req_dev), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_dev(rsp_dev),
    .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_va(fault_va),
    .fault_pid(fault_pid), .fault_dev(fault_dev), .fault_write(fault_write),
    .fault_ack(fault_ack), .fault_retry(fault_retry),
    .fill_valid(fill_valid), .fill_pid(fill_pid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_read(fill_read), .fill_write(fill_write), .fill_priv(fill_priv),
    .inv_valid(inv_valid), .inv_all(inv_all), .inv_pid(inv_pid)
  );

  typedef struct packed {
    logic             flt;
    logic [1:0]       cause;
    logic [PA_W-1:0]  pa;
    logic [VA_W-1:0]  va;
    logic [DEV_W-1:0] dev;
    logic [PID_W-1:0] pid;
    logic             wr;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int n_run = 0, n_fail = 0;
  logic fv_d = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each produced result against the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (rsp_valid || (fault_valid && !fv_d))) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected result", {63'd0, rsp_valid}, 64'd0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (e.flt) begin
            chk(fault_valid && !rsp_valid, {t, " fault kind"}, {63'd0, rsp_valid}, 64'd0);
            chk(fault_cause == e.cause, {t, " cause"}, 64'(fault_cause), 64'(e.cause));
            chk(fault_va == e.va && fault_pid == e.pid, {t, " R4 va/pid"}, 64'(fault_va), 64'(e.va));
            chk(fault_dev == e.dev && fault_write == e.wr, {t, " R4 dev/write"},
                64'({fault_dev, fault_write}), 64'({e.dev, e.wr}));
          end else begin
            chk(rsp_valid && !fault_valid, {t, " response kind"}, {63'd0, fault_valid}, 64'd0);
            chk(rsp_pa == e.pa && rsp_dev == e.dev, {t, " R1 pa/dev"}, 64'(rsp_pa), 64'(e.pa));
          end
        end
      end
      fv_d = fault_valid;
    end
  end

  function automatic exp_t mk(input bit flt, input logic [1:0] cause, input logic [PPN_W-1:0] ppn,
                              input logic [PID_W-1:0] pid, input logic [VA_W-1:0] va,
                              input logic [DEV_W-1:0] dev, input bit wr);
    exp_t e;
    e.flt = flt; e.cause = cause; e.pa = {ppn, va[11:0]};
    e.va = va; e.dev = dev; e.pid = pid; e.wr = wr;
    return e;
  endfunction

  // driver: push expectation, then present one request
  task automatic lookup(input logic [PID_W-1:0] pid, input logic [VA_W-1:0] va,
                        input logic [DEV_W-1:0] dev, input bit wr, input bit flt,
                        input logic [1:0] cause, input logic [PPN_W-1:0] ppn, input string tag);
    expq.push_back(mk(flt, cause, ppn, pid, va, dev, wr));
    tagq.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_pid = pid; req_va = va; req_dev = dev; req_write = wr;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic ack(input bit retry);
    while (!fault_valid) @(negedge clk);
    fault_ack = 1; fault_retry = retry;
    @(negedge clk);
    fault_ack = 0; fault_retry = 0;
  endtask

  task automatic fill(input logic [PID_W-1:0] pid, input logic [VPN_W-1:0] vpn,
                      input logic [PPN_W-1:0] ppn, input bit rd, input bit wr, input bit sup);
    @(negedge clk);
    fill_valid = 1; fill_pid = pid; fill_vpn = vpn; fill_ppn = ppn;
    fill_read = rd; fill_write = wr; fill_priv = sup;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inval(input bit all, input logic [PID_W-1:0] pid);
    @(negedge clk);
    inv_valid = 1; inv_all = all; inv_pid = pid;
    @(negedge clk);
    inv_valid = 0;
  endtask

  function automatic logic [VA_W-1:0] va_of(input logic [VPN_W-1:0] vpn, input logic [11:0] off);
    return {vpn, off};
  endfunction

  bit done = 0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk(req_ready && !rsp_valid && !fault_valid, "R11 idle after reset",
        {61'd0, req_ready, rsp_valid, fault_valid}, 64'd4);
    lookup(8'h01, va_of(36'h12345, 12'h678), 4'h1, 0, 1, 2'd0, '0, "R11 empty miss");
    chk(!req_ready, "R5 stall during fault", {63'd0, req_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk(fault_valid && fault_va == va_of(36'h12345, 12'h678), "R4 record held",
        64'(fault_va), 64'(va_of(36'h12345, 12'h678)));
    ack(0);
    chk(req_ready && !fault_valid, "R6 drop releases port", {63'd0, req_ready}, 64'd1);

    // R1 hits, read and write
    fill(8'h05, 36'hA_0001, 28'h0AB_CDE1, 1, 1, 0);
    lookup(8'h05, va_of(36'hA_0001, 12'h123), 4'h3, 0, 0, 2'd0, 28'h0AB_CDE1, "R1 read hit");
    lookup(8'h05, va_of(36'hA_0001, 12'hFFF), 4'h9, 1, 0, 2'd0, 28'h0AB_CDE1, "R1 write hit");
    // R2 other process misses
    lookup(8'h06, va_of(36'hA_0001, 12'h010), 4'h2, 0, 1, 2'd0, '0, "R2 pid mismatch");
    ack(0);
    // R3 permissions
    fill(8'h05, 36'hA_0002, 28'h000_0B02, 1, 0, 0);
    lookup(8'h05, va_of(36'hA_0002, 12'h004), 4'h4, 1, 1, 2'd2, '0, "R3 write to read-only");
    ack(0);
    lookup(8'h05, va_of(36'hA_0002, 12'h008), 4'h4, 0, 0, 2'd0, 28'h000_0B02, "R3 read of read-only");
    fill(8'h05, 36'hA_0003, 28'h000_0C03, 0, 1, 0);
    lookup(8'h05, va_of(36'hA_0003, 12'h00C), 4'h5, 0, 1, 2'd3, '0, "R3 read without read bit");
    ack(0);
    lookup(8'h05, va_of(36'hA_0003, 12'h00C), 4'h5, 1, 0, 2'd0, 28'h000_0C03, "R3 write-only write");
    fill(8'h05, 36'hA_0004, 28'h000_0D04, 0, 0, 1);
    lookup(8'h05, va_of(36'hA_0004, 12'h0A0), 4'h6, 1, 1, 2'd1, '0, "R3 privileged page first");
    ack(0);

    // R6 retry after servicing
    lookup(8'h07, va_of(36'hE_0005, 12'h321), 4'hB, 1, 1, 2'd0, '0, "R6 miss before service");
    fill(8'h07, 36'hE_0005, 28'h0E0_0E05, 1, 1, 0);
    chk(!req_ready, "R5 stall held across refill", {63'd0, req_ready}, 64'd0);
    expq.push_back(mk(0, 2'd0, 28'h0E0_0E05, 8'h07, va_of(36'hE_0005, 12'h321), 4'hB, 1));
    tagq.push_back("R6 replay hits");
    ack(1);
    chk(!req_ready, "R5 stall in replay cycle", {63'd0, req_ready}, 64'd0);
    repeat (2) @(negedge clk);
    // retry that faults again
    lookup(8'h07, va_of(36'hE_0006, 12'h001), 4'hC, 0, 1, 2'd0, '0, "R6 first miss");
    expq.push_back(mk(1, 2'd0, '0, 8'h07, va_of(36'hE_0006, 12'h001), 4'hC, 0));
    tagq.push_back("R6 replay faults again");
    ack(1);
    @(negedge clk);
    ack(0);
    // R6 acknowledge while idle is ignored
    @(negedge clk);
    fault_ack = 1; fault_retry = 1;
    @(negedge clk);
    fault_ack = 0; fault_retry = 0;
    repeat (2) @(negedge clk);
    chk(req_ready && !fault_valid && !rsp_valid, "R6 stray ack ignored",
        {62'd0, req_ready, fault_valid}, 64'd2);

    // R7 per-process invalidate
    inval(0, 8'h05);
    lookup(8'h05, va_of(36'hA_0001, 12'h000), 4'h1, 0, 1, 2'd0, '0, "R7 pid entries gone");
    ack(0);
    lookup(8'h07, va_of(36'hE_0005, 12'h000), 4'h1, 0, 0, 2'd0, 28'h0E0_0E05, "R7 other pid kept");

    // R10 lookup alongside global invalidate sees old contents, R8 clears all
    fill(8'h09, 36'h9_0007, 28'h090_0007, 1, 1, 0);
    expq.push_back(mk(0, 2'd0, 28'h090_0007, 8'h09, va_of(36'h9_0007, 12'h040), 4'h2, 0));
    tagq.push_back("R10 lookup with invalidate");
    @(negedge clk);
    req_valid = 1; req_pid = 8'h09; req_va = va_of(36'h9_0007, 12'h040); req_dev = 4'h2; req_write = 0;
    inv_valid = 1; inv_all = 1;
    @(negedge clk);
    req_valid = 0; inv_valid = 0; inv_all = 0;
    lookup(8'h09, va_of(36'h9_0007, 12'h040), 4'h2, 0, 1, 2'd0, '0, "R8 global clear");
    ack(0);
    lookup(8'h07, va_of(36'hE_0005, 12'h000), 4'h2, 0, 1, 2'd0, '0, "R8 global clear other pid");
    ack(0);
    // R10 refill together with invalidate survives
    @(negedge clk);
    fill_valid = 1; fill_pid = 8'h03; fill_vpn = 36'h3_0008; fill_ppn = 28'h030_0008;
    fill_read = 1; fill_write = 1; fill_priv = 0;
    inv_valid = 1; inv_all = 1;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0; inv_all = 0;
    lookup(8'h03, va_of(36'h3_0008, 12'h111), 4'h7, 0, 0, 2'd0, 28'h030_0008, "R10 refill beats invalidate");
    // R10 lookup alongside refill misses, later hits
    expq.push_back(mk(1, 2'd0, '0, 8'h03, va_of(36'h3_0009, 12'h222), 4'h7, 0));
    tagq.push_back("R10 lookup with refill");
    @(negedge clk);
    req_valid = 1; req_pid = 8'h03; req_va = va_of(36'h3_0009, 12'h222); req_dev = 4'h7; req_write = 0;
    fill_valid = 1; fill_pid = 8'h03; fill_vpn = 36'h3_0009; fill_ppn = 28'h030_0009;
    fill_read = 1; fill_write = 1; fill_priv = 0;
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
    ack(0);
    lookup(8'h03, va_of(36'h3_0009, 12'h222), 4'h7, 0, 0, 2'd0, 28'h030_0009, "R10 refill visible later");

    // R9 round-robin replacement and in-place overwrite
    inval(1, 8'h00);
    for (int k = 0; k < ENTRIES; k++) fill(8'h02, 36'h100 + k, 28'h200 + k, 1, 1, 0);
    fill(8'h02, 36'h101, 28'h3F1, 1, 1, 0);
    fill(8'h02, 36'h1FF, 28'h2FF, 1, 1, 0);
    lookup(8'h02, va_of(36'h100, 12'h0), 4'h1, 0, 1, 2'd0, '0, "R9 oldest evicted");
    ack(0);
    lookup(8'h02, va_of(36'h101, 12'h5), 4'h1, 0, 0, 2'd0, 28'h3F1, "R9 overwrite in place");
    lookup(8'h02, va_of(36'h102, 12'h6), 4'h1, 0, 0, 2'd0, 28'h202, "R9 neighbour kept");
    lookup(8'h02, va_of(36'h1FF, 12'h7), 4'h1, 0, 0, 2'd0, 28'h2FF, "R9 new key present");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R1 all expected results seen", 64'(expq.size()), 64'd0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule